// File: doc/BRIEF.md
# Frame-Buffer Span Fill Writer

This block sits between a processor bus and an 8-bit-per-pixel frame buffer. A single byte write from the bus can expand into a short burst of identical byte writes. The burst covers a span that depends on a fill mode and on the write address. Spans are aligned to groups of 4 pixels, or to groups of 20 pixels counted from the start of each 1024-byte scan line.

The fill mode is loaded by writing to a small register window; only the address of that write matters. Once a frame-buffer write is accepted, the block computes the first and last address of the span. It then writes one byte per clock, in ascending order, and holds the bus off until the last byte is written. Reads of the frame buffer pass straight through as single-byte accesses.

Top module: `vram_fill_writer`

## Requirements
- R1: A write with `req_sel_mode`=1 loads the fill mode from `req_addr[4:1]`; `req_addr[0]` and the data byte are ignored. Reset sets the mode to 0.
- R2: In mode 0, and in every mode value other than 1, 2, 3, 5, 9 and 13, a frame-buffer write stores only the addressed byte.
- R3: Mode 1 stores the byte at 4 consecutive addresses, beginning at the write address A.
- R4: Mode 2 fills from A rounded down to a multiple of 4, up to and including A.
- R5: Mode 3 fills from A up to and including the last address of A's aligned 4-byte group, that is A with its two low bits set.
- R6: Mode 5 stores the byte at 20 consecutive addresses, beginning at A.
- R7: Mode 9 fills from G = A - ((A mod 1024) mod 20) up to and including A with its two low bits set.
- R8: Mode 13 fills from A up to and including G + 19, with G as in R7.
- R9: A span of N bytes is written over the N clocks that follow the accepting edge, one byte per clock in ascending address order. `busy` is high during exactly those N clocks and `req_ready` is low during them.
- R10: A request presented while `busy` is high is held off, not lost. It is accepted on the first edge after the burst ends, and its span follows the earlier one.
- R11: A read (`req_write`=0, `req_sel_mode`=0) accepted while idle drives `mem_en`=1, `mem_we`=0 and `mem_addr`=`req_addr` in the same cycle. It returns `mem_rdata` on `rd_data` combinationally. The frame buffer is never written while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel_mode | input | 1 | 1 = mode register window, 0 = frame buffer |
| req_addr | input | 19 | Byte address (window offset when in the mode window) |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Request accepted on this edge when high |
| rd_data | output | 8 | Read data returned to the bus |
| busy | output | 1 | Burst in progress |
| mem_en | output | 1 | Frame-buffer access enable |
| mem_we | output | 1 | Frame-buffer write enable |
| mem_addr | output | 19 | Frame-buffer byte address |
| mem_wdata | output | 8 | Frame-buffer write data |
| mem_rdata | input | 8 | Frame-buffer read data |

## Verification
A corrupted mode register shows up at the first frame-buffer write after it. The burst starts at the wrong address or has the wrong length, and the bench catches that when it compares the logged write addresses with its own span. A wrong address counter or end comparison shows as a gap, a repeated address or a burst that never ends. The gap or repeat is visible within one clock of the faulty step. A burst that never ends keeps `busy` and `req_ready` stuck, so the next request stalls. Lost stalled requests show as a missing second span directly after the first.

// File: rtl/vfw_pkg.sv
package vfw_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    FM_SINGLE     = 4'd0,
    FM_QUAD_FWD   = 4'd1,
    FM_QUAD_BACK  = 4'd2,
    FM_QUAD_TAIL  = 4'd3,
    FM_GROUP_FWD  = 4'd5,
    FM_GROUP_BACK = 4'd9,
    FM_GROUP_TAIL = 4'd13
  } fill_mode_e;

  // Offset of an address from the start of its group, groups counted per line.
  function automatic logic [31:0] group_phase(logic [31:0] off, int line, int grp);
    return (off % line) % grp;
  endfunction

  function automatic logic [31:0] span_first(fill_mode_e m, logic [31:0] off,
                                             int line, int grp, int quad);
    case (m)
      FM_QUAD_BACK:  return off & ~(quad - 1);
      FM_GROUP_BACK: return off - group_phase(off, line, grp);
      default:       return off;
    endcase
  endfunction

  function automatic logic [31:0] span_last(fill_mode_e m, logic [31:0] off,
                                            int line, int grp, int quad);
    case (m)
      FM_QUAD_FWD:   return off + quad - 1;
      FM_QUAD_BACK:  return off;
      FM_QUAD_TAIL:  return off | (quad - 1);
      FM_GROUP_FWD:  return off + grp - 1;
      FM_GROUP_BACK: return off | (quad - 1);
      FM_GROUP_TAIL: return off + grp - 1 - group_phase(off, line, grp);
      default:       return off;
    endcase
  endfunction

endpackage

// File: rtl/vfw_mode_reg.sv
module vfw_mode_reg
  import vfw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] mode_in,
  output fill_mode_e        mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    mode_q <= FM_SINGLE;
    else if (load) mode_q <= fill_mode_e'(mode_in);
  end

  // R1: the mode only changes on a window write
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mode_q));

  // R1: a window write lands in the register
  p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q == $past(mode_in)));

endmodule

// File: rtl/vfw_span_calc.sv
module vfw_span_calc
  import vfw_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int LINE_BYTES = 1024,
  parameter int GROUP_BYTES = 20,
  parameter int QUAD_BYTES = 4
) (
  input  fill_mode_e        mode,
  input  logic [ADDR_W-1:0] off,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] last
);

  localparam int PAD = 32 - ADDR_W;

  logic [31:0] off_w;
  logic [31:0] first_w;
  logic [31:0] last_w;

  always_comb begin
    off_w   = {{PAD{1'b0}}, off};
    first_w = span_first(mode, off_w, LINE_BYTES, GROUP_BYTES, QUAD_BYTES);
    last_w  = span_last(mode, off_w, LINE_BYTES, GROUP_BYTES, QUAD_BYTES);
    first   = first_w[ADDR_W-1:0];
    last    = last_w[ADDR_W-1:0];
  end

endmodule

// File: rtl/vfw_burst_seq.sv
module vfw_burst_seq #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int MAX_SPAN = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              at_last,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              busy_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] last_q;
  logic [DATA_W-1:0] data_q;

  assign busy    = busy_q;
  assign at_last = busy_q && (cur_q == last_q);
  assign wr_addr = cur_q;
  assign wr_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cur_q  <= first;
        last_q <= last;
        data_q <= data;
      end
    end else if (at_last) begin
      busy_q <= 1'b0;
    end else begin
      cur_q <= cur_q + 1'b1;
    end
  end

  // R9: consecutive ascending addresses inside a burst
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !at_last) |=> (busy_q && cur_q == $past(cur_q) + 1'b1));

  // R9: the burst ends right after its last byte
  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> !busy_q);

  // R10: a new span only begins while idle
  p_accept_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> (cur_q == $past(cur_q) + 1'b1 || !busy_q));

  // R6: no span is longer than one group
  p_span_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |-> ((last - first) < ADDR_W'(MAX_SPAN)));

endmodule

// File: rtl/vram_fill_writer.sv
module vram_fill_writer
  import vfw_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 8,
  parameter int LINE_BYTES  = 1024,
  parameter int GROUP_BYTES = 20,
  parameter int QUAD_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_sel_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int WIN_AW = MODE_W + 1;

  logic              accept;
  logic              mode_load;
  logic              fill_start;
  logic              direct_read;
  logic              seq_busy;
  logic              seq_last;
  fill_mode_e        mode_q;
  logic [ADDR_W-1:0] span_lo;
  logic [ADDR_W-1:0] span_hi;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_data;

  assign req_ready   = !seq_busy;
  assign busy        = seq_busy;
  assign accept      = req_valid && req_ready;
  assign mode_load   = accept && req_write && req_sel_mode;
  assign fill_start  = accept && req_write && !req_sel_mode;
  assign direct_read = accept && !req_write && !req_sel_mode;

  vfw_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mode_load),
    .mode_in (req_addr[WIN_AW-1:1]),
    .mode_q  (mode_q)
  );

  vfw_span_calc #(
    .ADDR_W      (ADDR_W),
    .LINE_BYTES  (LINE_BYTES),
    .GROUP_BYTES (GROUP_BYTES),
    .QUAD_BYTES  (QUAD_BYTES)
  ) u_span (
    .mode  (mode_q),
    .off   (req_addr),
    .first (span_lo),
    .last  (span_hi)
  );

  vfw_burst_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MAX_SPAN (GROUP_BYTES)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fill_start),
    .first   (span_lo),
    .last    (span_hi),
    .data    (req_wdata),
    .busy    (seq_busy),
    .at_last (seq_last),
    .wr_addr (seq_addr),
    .wr_data (seq_data)
  );

  always_comb begin
    mem_en    = seq_busy || direct_read;
    mem_we    = seq_busy;
    mem_addr  = seq_busy ? seq_addr : req_addr;
    mem_wdata = seq_data;
    rd_data   = mem_rdata;
  end

  // R11: no frame-buffer write outside a burst
  p_no_idle_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !mem_we);

  // R9: the bus is held off for the whole burst
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> (seq_busy && !req_ready));

  // R9: the final byte of a burst is a write
  p_last_is_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |-> (mem_en && mem_we));

endmodule

// File: tb/tb_vram_fill_writer.sv
`timescale 1ns/1ps
module tb_vram_fill_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_sel_mode = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rd_data;
  logic        busy;
  logic        mem_en;
  logic        mem_we;
  logic [18:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

  vram_fill_writer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel_mode(req_sel_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_data(rd_data), .busy(busy), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // write log, sampled mid-cycle
  logic [18:0] log_a [0:63];
  logic [7:0]  log_d [0:63];
  int log_n = 0;
  int busy_n = 0;

  always @(negedge clk) begin
    if (busy) busy_n++;
    if (mem_en && mem_we) begin
      if (log_n < 64) begin
        log_a[log_n] = mem_addr;
        log_d[log_n] = mem_wdata;
      end
      log_n++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_first(int m, int a);
    int base;
    base = (a / 1024) * 1024 + (((a % 1024) / 20) * 20);
    if (m == 2) return (a / 4) * 4;
    if (m == 9) return base;
    return a;
  endfunction

  function automatic int exp_last(int m, int a);
    int base;
    base = (a / 1024) * 1024 + (((a % 1024) / 20) * 20);
    case (m)
      1:  return a + 3;
      3:  return (a / 4) * 4 + 3;
      5:  return a + 19;
      9:  return (a / 4) * 4 + 3;
      13: return base + 19;
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      5: return "R6";
      9: return "R7";
      13: return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic set_mode(int m);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel_mode = 1'b1;
    req_addr = 19'((m << 1) | int'($urandom_range(0, 1)));
    req_wdata = 8'($urandom);
    @(negedge clk);
    req_valid = 1'b0; req_sel_mode = 1'b0;
  endtask

  task automatic fill_and_check(int m, int a, logic [7:0] d);
    int f;
    int l;
    int n;
    bit ok;
    f = exp_first(m, a);
    l = exp_last(m, a);
    n = l - f + 1;
    @(negedge clk);
    log_n = 0;
    busy_n = 0;
    req_valid = 1'b1; req_write = 1'b1; req_sel_mode = 1'b0;
    req_addr = 19'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R9", "busy after accept", int'(busy), 1);
    while (busy) @(negedge clk);
    check(log_n == n, tag_of(m), "span length", log_n, n);
    check(busy_n == n, "R9", "busy cycles", busy_n, n);
    if (log_n == n && n <= 64) begin
      ok = 1'b1;
      for (int i = 0; i < n; i++)
        if (log_a[i] != 19'(f + i) || log_d[i] != d) ok = 1'b0;
      check(ok, tag_of(m), "span addresses/data", int'(log_a[0]), f);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // reset state
    check(!busy && req_ready && !mem_en, "R9", "idle in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && req_ready, "R1", "idle after reset", int'(req_ready), 1);

    // R1: mode is 0 after reset -> single byte
    fill_and_check(0, 100, 8'h3C);

    // R11: read passes through
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_write = 1'b0; req_sel_mode = 1'b0; req_addr = 19'h1234;
    #1;
    check(mem_en && !mem_we, "R11", "read strobes", int'(mem_we), 0);
    check(mem_addr == 19'h1234, "R11", "read addr", int'(mem_addr), 32'h1234);
    check(rd_data == (8'h34 ^ 8'hA5), "R11", "read data", int'(rd_data), 32'h34 ^ 32'hA5);
    @(negedge clk);
    req_valid = 1'b0;
    check(log_n == 0 && !busy, "R11", "read wrote nothing", log_n, 0);

    // directed corners
    set_mode(9);  fill_and_check(9, 1023, 8'h11);   // group 1020..1023
    set_mode(9);  fill_and_check(9, 2048 + 39, 8'h12);
    set_mode(13); fill_and_check(13, 1021, 8'h13);  // crosses line
    set_mode(13); fill_and_check(13, 40, 8'h14);
    set_mode(2);  fill_and_check(2, 7, 8'h15);
    set_mode(3);  fill_and_check(3, 8, 8'h16);
    set_mode(7);  fill_and_check(7, 500, 8'h17);    // unsupported -> R2
    set_mode(5);  fill_and_check(5, 333, 8'h18);
    set_mode(1);  fill_and_check(1, 0, 8'h19);

    // R10: write presented during a burst is stalled, then runs
    set_mode(1);
    @(negedge clk);
    log_n = 0;
    req_valid = 1'b1; req_write = 1'b1; req_sel_mode = 1'b0;
    req_addr = 19'd600; req_wdata = 8'hAA;
    @(negedge clk);
    req_addr = 19'd900; req_wdata = 8'hBB;
    check(!req_ready, "R10", "ready low while busy", int'(req_ready), 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    check(log_n == 8, "R10", "both spans written", log_n, 8);
    check(log_a[4] == 19'd900 && log_d[4] == 8'hBB, "R10", "second span start",
          int'(log_a[4]), 900);
    check(log_a[3] == 19'd603, "R10", "first span end", int'(log_a[3]), 603);

    // random
    for (int it = 0; it < 200; it++) begin
      int k;
      int m;
      int a;
      k = int'($urandom_range(0, 7));
      case (k)
        0: m = 0; 1: m = 1; 2: m = 2; 3: m = 3;
        4: m = 5; 5: m = 9; 6: m = 13;
        default: begin
          m = int'($urandom_range(4, 15));
          while (m == 5 || m == 9 || m == 13) m = int'($urandom_range(4, 15));
        end
      endcase
      a = int'($urandom_range(0, 32'h7FF00));
      set_mode(m);
      fill_and_check(m, a, 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule